// File: doc/BRIEF.md
# Parallel Multi-Lane Additive Scrambler

This block scrambles several serial lanes at once. Each lane owns a 23-bit linear-feedback generator. The generator advances 32 serial steps in every clock that carries a word. The generator bits produced in those steps form a keystream word, and the keystream is XORed into the lane's 32-bit data word. The incoming data never enters the generator, so the descrambler at the far end is the same block with the same seeds.

The generator is written bit-serially only at elaboration time. A constant function feeds each of the 23 state bits through the serial recurrence on its own and records where that bit lands. Those records become fixed XOR masks. Each next-state bit and each keystream bit is then one masked XOR reduction of the current state. Every lane starts from its own seed. A per-lane reseed input restores that seed in one cycle. Words marked as ordered-set travel unscrambled but still use up keystream.

Top module: `par_scrambler`

## Requirements
- R1: While reset is asserted, every `valid_o` bit and all of `data_o` are zero. The first word after reset is scrambled from the lane's seed.
- R2: A valid payload word (`valid_i`=1, `os_i`=0, `reseed_i`=0) appears on `data_o` one clock later as data XOR keystream, with `valid_o`=1. Keystream bit i (bit 0 first) is the output of serial step i. A serial step emits s[22], then shifts the state left by one, and the new s[0] is s[22]^s[20]^s[15]^s[7]^s[4]^s[1]. This is the polynomial x^23+x^21+x^16+x^8+x^5+x^2+1.
- R3: Each valid word that is not a reseed advances the generator by exactly 32 serial steps. Words that follow later use the state reached this way.
- R4: When `valid_i` is 0 and `reseed_i` is 0, the generator holds its state. One clock later `data_o` equals the input word unchanged and `valid_o` is 0.
- R5: When `valid_i` and `os_i` are both 1, the word passes through unscrambled one clock later with `valid_o`=1, and the generator still advances 32 steps.
- R6: `reseed_i` reloads the lane seed within one clock. It takes priority over advancing. The word presented in that cycle passes through unscrambled, and `valid_o` follows `valid_i`.
- R7: Lanes are independent. Lane k uses seed 0x1DBFBC XOR ((k*0x3A7) mod 2^23), so every lane has a different seed and no seed is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | LANES | Word valid, one bit per lane |
| os_i | input | LANES | Word is an ordered set: pass through unscrambled |
| reseed_i | input | LANES | Reload the lane seed |
| data_i | input | LANES*32 | Input words, lane k at bits [32k+31:32k] |
| data_o | output | LANES*32 | Scrambled words, registered |
| valid_o | output | LANES | Registered valid |

## Verification
The generator state is never visible at the ports directly. Any fault in it shows up in the keystream of the next valid payload word on that lane, one clock after the word is presented. The fault then persists on every later word until a reseed is applied. Faults in the hold and advance logic appear only after a gap or an ordered-set word, so the stimulus mixes idle cycles, ordered sets and reseeds among the payload words. Each output word is compared with a bit-serial model that walks all 32 steps.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int ST_W = 23;
  // feedback taps: stages 23,21,16,8,5,2
  localparam logic [ST_W-1:0] FB_TAPS   = 23'h508092;
  localparam logic [ST_W-1:0] SEED_BASE = 23'h1DBFBC;
  localparam logic [ST_W-1:0] SEED_STEP = 23'h0003A7;

  typedef logic [ST_W-1:0] mask_t;
  typedef mask_t [ST_W-1:0] state_map_t;

  function automatic mask_t lane_seed(input int k);
    logic [ST_W-1:0] kk;
    kk = ST_W'(k);
    return SEED_BASE ^ ST_W'(kk * SEED_STEP);
  endfunction
endpackage

// File: rtl/scr_step.sv
module scr_step
  import scr_pkg::*;
#(
  parameter int DW = 32
) (
  input  mask_t        state_i,
  output mask_t        state_o,
  output logic [DW-1:0] key_o
);
  typedef mask_t [DW-1:0] key_map_t;

  // superposition: track where each state bit lands after n serial steps
  function automatic state_map_t build_nxt();
    state_map_t sym;
    mask_t fb;
    for (int b = 0; b < ST_W; b++) sym[b] = mask_t'(1) << b;
    for (int n = 0; n < DW; n++) begin
      fb = '0;
      for (int b = 0; b < ST_W; b++) if (FB_TAPS[b]) fb ^= sym[b];
      for (int b = ST_W-1; b > 0; b--) sym[b] = sym[b-1];
      sym[0] = fb;
    end
    return sym;
  endfunction

  function automatic key_map_t build_key();
    state_map_t sym;
    key_map_t key;
    mask_t fb;
    for (int b = 0; b < ST_W; b++) sym[b] = mask_t'(1) << b;
    for (int n = 0; n < DW; n++) begin
      key[n] = sym[ST_W-1];
      fb = '0;
      for (int b = 0; b < ST_W; b++) if (FB_TAPS[b]) fb ^= sym[b];
      for (int b = ST_W-1; b > 0; b--) sym[b] = sym[b-1];
      sym[0] = fb;
    end
    return key;
  endfunction

  localparam state_map_t NXT_MAP = build_nxt();
  localparam key_map_t   KEY_MAP = build_key();

  for (genvar j = 0; j < ST_W; j++) begin : g_nxt
    assign state_o[j] = ^(state_i & NXT_MAP[j]);
  end
  for (genvar i = 0; i < DW; i++) begin : g_key
    assign key_o[i] = ^(state_i & KEY_MAP[i]);
  end
endmodule

// File: rtl/scr_lane.sv
module scr_lane
  import scr_pkg::*;
#(
  parameter int    DW   = 32,
  parameter mask_t SEED = SEED_BASE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          os_i,
  input  logic          reseed_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          valid_o
);
  mask_t         state_q, state_nxt;
  logic [DW-1:0] key;
  logic          scramble;

  scr_step #(.DW(DW)) u_step (
    .state_i(state_q),
    .state_o(state_nxt),
    .key_o  (key)
  );

  assign scramble = valid_i && !os_i && !reseed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEED;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      data_o  <= scramble ? (data_i ^ key) : data_i;
      if (reseed_i)     state_q <= SEED;
      else if (valid_i) state_q <= state_nxt;
    end
  end

  assert_seed_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !reseed_i) |=> $stable(state_q));
  assert_pass_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (data_o == $past(data_i)) && !valid_o);
  assert_pass_os_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && os_i) |=> (data_o == $past(data_i)) && valid_o);
  assert_reseed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reseed_i |=> (state_q == SEED));
  assert_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !reseed_i) |=> (state_q != $past(state_q)));
endmodule

// File: rtl/par_scrambler.sv
module par_scrambler
  import scr_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DW    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [LANES-1:0]    valid_i,
  input  logic [LANES-1:0]    os_i,
  input  logic [LANES-1:0]    reseed_i,
  input  logic [LANES*DW-1:0] data_i,
  output logic [LANES*DW-1:0] data_o,
  output logic [LANES-1:0]    valid_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    scr_lane #(.DW(DW), .SEED(lane_seed(k))) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (valid_i[k]),
      .os_i    (os_i[k]),
      .reseed_i(reseed_i[k]),
      .data_i  (data_i[k*DW +: DW]),
      .data_o  (data_o[k*DW +: DW]),
      .valid_o (valid_o[k])
    );
  end

  assert_reset_quiet_R1: assert property (@(posedge clk_i) !rst_ni |=> (valid_o == '0) || rst_ni);
endmodule

// File: tb/par_scrambler_test.sv
module par_scrambler_test;
  localparam int L  = 4;
  localparam int DW = 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [L-1:0]    valid_i = '0, os_i = '0, reseed_i = '0;
  logic [L*DW-1:0] data_i = '0;
  logic [L*DW-1:0] data_o;
  logic [L-1:0]    valid_o;

  int checks = 0, fails = 0, cyc = 0;
  logic [22:0] mst [L];

  par_scrambler #(.LANES(L), .DW(DW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .os_i(os_i),
    .reseed_i(reseed_i), .data_i(data_i), .data_o(data_o), .valid_o(valid_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [22:0] seed_of(input int k);
    logic [22:0] m;
    m = 23'(k * 32'h3A7);
    return 23'h1DBFBC ^ m;
  endfunction

  // bit-serial model: returns {next state, keystream}
  function automatic logic [54:0] serial_run(input logic [22:0] s);
    logic [31:0] ks;
    logic fb;
    for (int n = 0; n < 32; n++) begin
      ks[n] = s[22];
      fb = s[22] ^ s[20] ^ s[15] ^ s[7] ^ s[4] ^ s[1];
      s = {s[21:0], fb};
    end
    return {s, ks};
  endfunction

  task automatic chk(input string req, input int lane, input logic [31:0] act_d,
                     input logic [31:0] exp_d, input logic act_v, input logic exp_v);
    checks++;
    if (act_d !== exp_d || act_v !== exp_v) begin
      fails++;
      $display("FAIL %s lane %0d: data %h valid %b, expected data %h valid %b",
               req, lane, act_d, act_v, exp_d, exp_v);
    end
  endtask

  // drive one word per lane, then compare after the next rising edge
  task automatic cycle(input logic [L-1:0] v, input logic [L-1:0] o,
                       input logic [L-1:0] r, input logic [L*DW-1:0] d, input string tag);
    logic [31:0] exp_d [L];
    logic        exp_v [L];
    string       req [L];
    logic [54:0] res;
    valid_i = v; os_i = o; reseed_i = r; data_i = d;
    for (int k = 0; k < L; k++) begin
      res = serial_run(mst[k]);
      exp_v[k] = v[k];
      if (r[k]) begin
        exp_d[k] = d[k*DW +: DW]; mst[k] = seed_of(k); req[k] = "R6";
      end else if (!v[k]) begin
        exp_d[k] = d[k*DW +: DW]; req[k] = "R4";
      end else if (o[k]) begin
        exp_d[k] = d[k*DW +: DW]; mst[k] = res[54:32]; req[k] = "R5";
      end else begin
        exp_d[k] = d[k*DW +: DW] ^ res[31:0]; mst[k] = res[54:32]; req[k] = tag;
      end
    end
    @(negedge clk_i);
    for (int k = 0; k < L; k++)
      chk(req[k], k, data_o[k*DW +: DW], exp_d[k], valid_o[k], exp_v[k]);
  endtask

  function automatic logic [L*DW-1:0] rnd_data();
    logic [L*DW-1:0] d;
    for (int k = 0; k < L; k++) d[k*DW +: DW] = $urandom;
    return d;
  endfunction

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: cycles %0d, expected below %0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < L; k++) mst[k] = seed_of(k);
    data_i = rnd_data(); valid_i = '1;
    repeat (3) @(negedge clk_i);
    for (int k = 0; k < L; k++) chk("R1", k, data_o[k*DW +: DW], 32'h0, valid_o[k], 1'b0);
    rst_ni = 1'b1;
    // first word from seed, all lanes zero data: keystream per lane
    cycle('1, '0, '0, '0, "R1");
    begin
      logic [31:0] ks [L];
      for (int k = 0; k < L; k++) ks[k] = serial_run(seed_of(k))[31:0];
      for (int k = 1; k < L; k++) begin
        checks++;
        if (ks[k] == ks[0] || seed_of(k) == 23'h0) begin
          fails++;
          $display("FAIL R7 lane %0d: keystream %h, expected differ from %h", k, ks[k], ks[0]);
        end
      end
    end
    // consecutive words: multi-step advance
    repeat (4) cycle('1, '0, '0, rnd_data(), "R3");
    // idle gap then resume
    repeat (3) cycle('0, '0, '0, rnd_data(), "R4");
    cycle('1, '0, '0, rnd_data(), "R3");
    // ordered set then payload
    cycle('1, '1, '0, rnd_data(), "R5");
    cycle('1, '0, '0, rnd_data(), "R3");
    // reseed with valid and without, on a subset
    cycle('1, '0, 4'b0101, rnd_data(), "R2");
    cycle(4'b0000, '0, 4'b1010, rnd_data(), "R2");
    cycle('1, '0, '0, '1, "R2");
    // independent lanes: single lane active
    cycle(4'b0100, '0, '0, rnd_data(), "R7");
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [L-1:0] v, o, r;
      v = L'($urandom); o = L'($urandom) & L'($urandom);
      r = ($urandom % 8 == 0) ? L'($urandom) : '0;
      cycle(v, o, r, rnd_data(), "R2");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule